// File: doc/BRIEF.md
# Arithmetic Unit with Stored Flags and Branch Decision

This block pairs a purely combinational integer arithmetic/logic unit with a small three-flag status register and a branch-condition decoder. The arithmetic side takes two operands, `op_a` and `op_b`, and a 4-bit operation selector. It returns their sum, the difference `op_b - op_a`, their bitwise AND or their bitwise XOR, all in the same cycle. When the flag-load strobe is high and the selector holds a defined operation, the overflow, zero and sign flags of that result are captured on the next rising clock edge.

The branch side reads a 4-bit condition selector and checks it against the stored flags only, never against the current result. It drives a single take-branch decision. A pipeline uses the block by issuing an operation with the flag-load strobe in one cycle, then asking any later cycle whether a conditional jump is taken.

The stored flags form a small state register with two transitions. The HOLD transition keeps the flags when the strobe is low or the selector is undefined. The CAPTURE transition overwrites all three flags from the current result. Reset places the register in its initial state: zero flag set, sign and overflow clear.

Top module: `alu_cc_unit`

## Requirements
- R1: Selector value 0 drives `result` with `op_a + op_b` modulo 2^WIDTH in the same cycle.
- R2: Selector value 1 drives `result` with `op_b - op_a` modulo 2^WIDTH, so the first operand is taken away from the second.
- R3: Selector value 2 drives the bitwise AND of the operands and selector value 3 drives their bitwise XOR.
- R4: Selector values 4 through 15 drive a `result` of zero, and the stored flags stay unchanged even when `cc_load` is high.
- R5: When `cc_load` is high with a selector of 0 to 3, the next rising edge stores zero flag = (result is zero) and sign flag = the result's most significant bit.
- R6: For addition the stored overflow flag is set exactly when both operands share a sign and the sum's sign differs from it.
- R7: For subtraction the stored overflow flag is set exactly when the true signed value of `op_b - op_a` lies outside the signed WIDTH-bit range; for AND and XOR it is stored as zero.
- R8: When `cc_load` is low the stored flags keep their value across clock edges.
- R9: While `rst_n` is low the flags read zero=1, sign=0, overflow=0.
- R10: With lt = sign XOR overflow, condition codes give: 0 always taken, 1 lt OR zero, 2 lt, 3 zero, 4 NOT zero, 5 NOT lt, 6 NOT lt AND NOT zero; all are computed from the stored flags.
- R11: Condition codes 7 through 15 give `take_branch` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| fn_code | input | 4 | Operation selector: 0 add, 1 subtract, 2 AND, 3 XOR |
| op_a | input | WIDTH | First operand (subtrahend for subtract) |
| op_b | input | WIDTH | Second operand (minuend for subtract) |
| cc_load | input | 1 | Capture the flags of the current result on the next edge |
| jmp_fn | input | 4 | Branch condition selector, codes 0 to 6 defined |
| result | output | WIDTH | Combinational operation result |
| flag_of | output | 1 | Stored signed-overflow flag |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored sign flag |
| take_branch | output | 1 | Branch decision from the stored flags |

## Verification
The bench builds the block with the default WIDTH of 32. At that width the operands can be placed on the signed extremes 0x7FFFFFFF and 0x80000000, where both overflow rules change their answer, and a zero result can be forced from non-zero inputs. Directed steps walk every condition code over flag states with lt and zero set in each combination. A long random sequence mixes defined and undefined selectors with the load strobe toggling. A wide-integer model in the bench predicts the result, flags and branch decision on every cycle.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    typedef enum logic [3:0] {
        OP_SUM  = 4'd0,
        OP_DIFF = 4'd1,
        OP_CONJ = 4'd2,
        OP_EXOR = 4'd3
    } op_sel_e;

    typedef enum logic [3:0] {
        BR_ANY   = 4'd0,
        BR_LE    = 4'd1,
        BR_LT    = 4'd2,
        BR_EQ    = 4'd3,
        BR_NE    = 4'd4,
        BR_GE    = 4'd5,
        BR_GT    = 4'd6
    } br_sel_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic neg;
    } flag_set_t;

    localparam flag_set_t FLAGS_INIT = '{ovf: 1'b0, zero: 1'b1, neg: 1'b0};
    localparam logic [3:0] OP_COUNT  = 4'd4;

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       sel,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] res,
    output flag_set_t        flags_nx,
    output logic             sel_ok
);
    localparam int MSB = WIDTH - 1;

    logic             is_diff;
    logic [WIDTH-1:0] addend;
    logic [WIDTH-1:0] sum;
    logic             sum_ovf;

    // One adder serves both sum and difference: b + ~a + 1 == b - a.
    always_comb begin
        is_diff = (sel == OP_DIFF);
        addend  = is_diff ? ~a_in : a_in;
        sum     = b_in + addend + {{(WIDTH-1){1'b0}}, is_diff};
        sum_ovf = (addend[MSB] == b_in[MSB]) && (sum[MSB] != b_in[MSB]);
    end

    always_comb begin
        res          = '0;
        flags_nx.ovf = 1'b0;
        unique case (sel)
            OP_SUM,
            OP_DIFF: begin
                res          = sum;
                flags_nx.ovf = sum_ovf;
            end
            OP_CONJ: res = a_in & b_in;
            OP_EXOR: res = a_in ^ b_in;
            default: res = '0;
        endcase
        flags_nx.zero = (res == '0);
        flags_nx.neg  = res[MSB];
        sel_ok        = (sel < OP_COUNT);
    end

endmodule

// File: rtl/cc_reg.sv
module cc_reg
    import alu_cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  flag_set_t d,
    output flag_set_t q
);
    typedef enum logic {HOLD, CAPTURE} cc_move_e;

    cc_move_e  move;
    flag_set_t q_nx;

    always_comb begin
        move = load ? CAPTURE : HOLD;
        unique case (move)
            CAPTURE: q_nx = d;
            HOLD:    q_nx = q;
            default: q_nx = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FLAGS_INIT;
        else        q <= q_nx;
    end

    // R8: flags only move on a capture
    a_r8_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import alu_cc_pkg::*;
(
    input  flag_set_t  flags,
    input  logic [3:0] cond,
    output logic       take
);
    logic lt;

    always_comb begin
        lt = flags.neg ^ flags.ovf;
        case (cond)
            BR_ANY:  take = 1'b1;
            BR_LE:   take = lt | flags.zero;
            BR_LT:   take = lt;
            BR_EQ:   take = flags.zero;
            BR_NE:   take = ~flags.zero;
            BR_GE:   take = ~lt;
            BR_GT:   take = ~lt & ~flags.zero;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       fn_code,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             cc_load,
    input  logic [3:0]       jmp_fn,
    output logic [WIDTH-1:0] result,
    output logic             flag_of,
    output logic             flag_zf,
    output logic             flag_sf,
    output logic             take_branch
);
    flag_set_t flags_nx;
    flag_set_t flags_q;
    logic      sel_ok;

    alu_core #(.WIDTH(WIDTH)) u_core (
        .sel      (fn_code),
        .a_in     (op_a),
        .b_in     (op_b),
        .res      (result),
        .flags_nx (flags_nx),
        .sel_ok   (sel_ok)
    );

    cc_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cc_load & sel_ok),
        .d     (flags_nx),
        .q     (flags_q)
    );

    branch_eval u_branch (
        .flags (flags_q),
        .cond  (jmp_fn),
        .take  (take_branch)
    );

    assign flag_of = flags_q.ovf;
    assign flag_zf = flags_q.zero;
    assign flag_sf = flags_q.neg;

    // R4: undefined selectors leave flags alone even with the strobe high
    a_r4_undef_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_load && fn_code >= 4'd4) |=> ($stable(flag_of) && $stable(flag_zf) && $stable(flag_sf)));

    // R5: a capture stores the zero and sign of the presented result
    a_r5_capture_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_load && fn_code < 4'd4) |=> (flag_zf == ($past(result) == '0)) && (flag_sf == $past(result[WIDTH-1])));

    // R7: logical operations clear overflow
    a_r7_logic_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_load && (fn_code == 4'd2 || fn_code == 4'd3)) |=> !flag_of);

    // R9: reset state of the flags
    a_r9_reset_flags: assert property (@(posedge clk)
        !rst_n |-> (flag_zf && !flag_sf && !flag_of));

    // R10: equality condition follows the stored zero flag
    a_r10_eq_follows_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_fn == 4'd3) |-> (take_branch == flag_zf));

    // R11: undefined conditions never branch
    a_r11_undef_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_fn > 4'd6) |-> !take_branch);

endmodule

// File: tb/alu_cc_unit_tb_top.sv
`timescale 1ns/1ps
module alu_cc_unit_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [3:0]   fn_code = '0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         cc_load = 1'b0;
    logic [3:0]   jmp_fn = '0;
    logic [W-1:0] result;
    logic         flag_of, flag_zf, flag_sf, take_branch;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference flag state
    bit m_of = 0, m_zf = 1, m_sf = 0;

    always #2 clk = ~clk;

    alu_cc_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .fn_code(fn_code), .op_a(op_a), .op_b(op_b),
        .cc_load(cc_load), .jmp_fn(jmp_fn), .result(result),
        .flag_of(flag_of), .flag_zf(flag_zf), .flag_sf(flag_sf), .take_branch(take_branch)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_take(input int j, input bit of, input bit zf, input bit sf);
        bit lt = sf ^ of;
        case (j)
            0: return 1;
            1: return lt | zf;
            2: return lt;
            3: return zf;
            4: return !zf;
            5: return !lt;
            6: return !lt && !zf;
            default: return 0;
        endcase
    endfunction

    task automatic step(input int fn, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit ld, input int j, input string ftag);
        logic [W-1:0] r;
        longint sa, sb, wide;
        bit of;
        string rtag;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        of = 0;
        case (fn)
            0: begin r = a + b; wide = sa + sb; of = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); rtag = "R1"; end
            1: begin r = b - a; wide = sb - sa; of = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); rtag = "R2"; end
            2: begin r = a & b; rtag = "R3"; end
            3: begin r = a ^ b; rtag = "R3"; end
            default: begin r = '0; rtag = "R4"; end
        endcase
        @(negedge clk);
        fn_code = 4'(fn); op_a = a; op_b = b; cc_load = ld; jmp_fn = 4'(j);
        #1;
        check(rtag, "result", longint'(result), longint'(r));
        check((j <= 6) ? "R10" : "R11", "take_branch", longint'(take_branch),
              longint'(ref_take(j, m_of, m_zf, m_sf)));
        @(posedge clk);
        if (ld && fn < 4) begin
            m_of = of; m_zf = (r == '0); m_sf = r[W-1];
        end
        #1;
        check(ftag, "flag_of", longint'(flag_of), longint'(m_of));
        check(ftag, "flag_zf", longint'(flag_zf), longint'(m_zf));
        check(ftag, "flag_sf", longint'(flag_sf), longint'(m_sf));
    endtask

    task automatic sweep_jumps();
        for (int j = 0; j < 16; j++) step(0, 32'd0, 32'd0, 0, j, "R8");
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9", "flag_zf", longint'(flag_zf), 1);
        check("R9", "flag_sf", longint'(flag_sf), 0);
        check("R9", "flag_of", longint'(flag_of), 0);
        jmp_fn = 4'd1; #1;
        check("R9", "take le at reset", longint'(take_branch), 1);
        jmp_fn = 4'd6; #1;
        check("R9", "take g at reset", longint'(take_branch), 0);
        rst_n = 1'b1;

        step(0, 32'd5, 32'd7, 1, 0, "R5");
        step(0, 32'h7fffffff, 32'd1, 1, 6, "R6");
        sweep_jumps();                                         // neg, ovf: lt=0
        step(0, 32'h80000000, 32'h80000000, 1, 3, "R6");
        sweep_jumps();                                         // zero, ovf
        step(0, 32'hffffffff, 32'hfffffffe, 1, 2, "R6");
        sweep_jumps();                                         // neg only: lt=1
        step(1, 32'd3, 32'd10, 1, 1, "R5");
        step(1, 32'd10, 32'd3, 1, 5, "R5");
        step(1, 32'd1, 32'h80000000, 1, 4, "R7");
        sweep_jumps();                                         // ovf only: lt=1
        step(1, 32'hffffffff, 32'h7fffffff, 1, 2, "R7");
        step(1, 32'h1234, 32'h1234, 1, 3, "R5");
        sweep_jumps();                                         // zero only
        step(1, 32'd7, 32'd2, 1, 0, "R7");
        step(2, 32'hf0f0f0f0, 32'h8ff00f0f, 1, 0, "R7");
        step(3, 32'hdeadbeef, 32'hdeadbeef, 1, 3, "R7");
        step(0, 32'd1, 32'd1, 1, 0, "R5");
        step(9, 32'h80000000, 32'h80000000, 1, 0, "R4");
        step(15, 32'h0, 32'h0, 1, 0, "R4");
        step(0, 32'h80000000, 32'h80000000, 0, 0, "R8");
        step(1, 32'd0, 32'd0, 0, 3, "R8");
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            int f;
            ra = $urandom;
            rb = $urandom;
            if (i % 5 == 0) rb = ra;
            if (i % 7 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
            f = (i % 3 == 0) ? int'($urandom % 16) : int'($urandom % 4);
            step(f, ra, rb, bit'($urandom % 2), int'($urandom % 16), "R5");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule